// File: doc/BRIEF.md
# Burst-Four Wide-Word SRAM Datapath

This block is the data path of a synchronous burst memory. Every access moves a burst of four beats over a narrow data bus, and the storage array holds each burst as one word four beats wide. Double-data-rate transfer is modelled as two lanes per clock: lane 0 carries the beat of the first half-cycle and lane 1 the beat of the second. A burst therefore takes two consecutive cycles.

On a write, an input de-multiplexer collects the four beats and their per-beat byte enables. The finished word is kept in a pending register. It goes into the array, with its byte enables, when the next write burst completes. On a read, the array word is read once and merged byte by byte with the pending write if the addresses match. An output multiplexer then sends the word out two beats per cycle.

On the wide bus variants (18 or 36 bits), the two low address bits choose the starting beat, and the burst wraps linearly from that beat. On the narrow variants (8 or 9 bits), the address holds only the word index and every burst starts at beat 0.

Top module: `burst4_sram_dp`

## Requirements
- R1: After reset, `rd_vld` and `cmd_err` are low and both read lanes are zero.
- R2: A write command is accepted with `cmd_vld`=1 and `cmd_wr`=1. Beats 0 and 1 are taken from lanes 0 and 1 in the command cycle, and beats 2 and 3 in the next cycle. A later read of the same word with the same start offset returns the four beats in the same order.
- R3: A read command (`cmd_vld`=1, `cmd_wr`=0) in cycle C raises `rd_vld` in cycles C+2 and C+3. Beats 0 and 1 are on lanes 0 and 1 in cycle C+2, and beats 2 and 3 in cycle C+3.
- R4: On wide variants, `cmd_addr` is {word index, start s}, with s in bits 1:0. Beat k of the burst maps to word slice (s+k) mod 4, for writes and for reads alike.
- R5: On narrow variants, `cmd_addr` is the word index only, and beat k always maps to slice k.
- R6: Bit l of a beat's byte enable gates lane field l of that beat. The field is 9 bits wide, or 4 bits on the 8-bit variant. A field whose enable is 0 keeps its previous stored value.
- R7: A read of a word whose write is still pending returns the newly written fields, with unwritten fields taken from the older contents, for every beat.
- R8: At most one command is accepted every second cycle. A command in the cycle right after an accepted one is ignored, changes neither storage nor outputs, and raises `cmd_err` for exactly the next cycle.
- R9: While `rd_vld` is low, both read lanes are zero.
- R10: Reads issued every second cycle produce `rd_vld` high without a gap, each burst in its own two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_vld | input | 1 | Command strobe |
| cmd_wr | input | 1 | 1 = write burst, 0 = read burst |
| cmd_addr | input | PAW | Word index, plus start offset in bits 1:0 on wide variants |
| wr_d0 | input | DW | Write beat on lane 0 (first half-cycle) |
| wr_d1 | input | DW | Write beat on lane 1 (second half-cycle) |
| wr_be0 | input | NL | Byte enables for the lane 0 beat |
| wr_be1 | input | NL | Byte enables for the lane 1 beat |
| rd_d0 | output | DW | Read beat on lane 0 |
| rd_d1 | output | DW | Read beat on lane 1 |
| rd_vld | output | 1 | Read beats valid |
| cmd_err | output | 1 | Ignored-command flag |

## Verification
The wide variant is first filled with full writes at rotating start offsets. Every word is then read back at all four offsets, which tells a correct wrap apart from a fixed or reversed beat order. Random partial writes are followed at once by a read of the same word, which exercises the pending-write merge. Other partial writes are followed by a write elsewhere before the read, so the array commit path is checked separately from the bypass. Stray commands in the second cycle of a read or a write show whether an ignored command leaks into storage or outputs. A narrow 9-bit instance shows that the address does not rotate the beats and that disabled fields are kept.

// File: rtl/b4_pkg.sv
`timescale 1ns/1ps
package b4_pkg;
  localparam int BURST = 4;

  typedef logic [1:0] beat_ptr_t;

  // byte-enable fields per beat for a given bus width
  function automatic int lanes_for(input int dw);
    if (dw == 8) return 2;
    if (dw == 9) return 1;
    return dw / 9;
  endfunction

  function automatic bit is_wide(input int dw);
    return (dw >= 18);
  endfunction
endpackage

// File: rtl/b4_cmd_gate.sv
`timescale 1ns/1ps
module b4_cmd_gate
  import b4_pkg::*;
#(
  parameter int AW   = 6,
  parameter int PAW  = 8,
  parameter bit WIDE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_vld,
  input  logic          cmd_wr,
  input  logic [PAW-1:0] cmd_addr,
  output logic          acc_wr,
  output logic          acc_rd,
  output beat_ptr_t     start,
  output logic [AW-1:0] idx,
  output logic          cmd_err
);
  logic busy_q, busy_d;
  logic err_q, err_d;
  logic acc;

  generate
    if (WIDE) begin : g_wide
      assign start = cmd_addr[1:0];
      assign idx   = cmd_addr[PAW-1:2];
    end else begin : g_narrow
      assign start = '0;
      assign idx   = cmd_addr;
    end
  endgenerate

  assign acc    = cmd_vld & ~busy_q;
  assign acc_wr = acc & cmd_wr;
  assign acc_rd = acc & ~cmd_wr;

  always_comb begin
    busy_d = acc;
    err_d  = cmd_vld & busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
    end
  end

  assign cmd_err = err_q;
endmodule

// File: rtl/b4_wr_demux.sv
`timescale 1ns/1ps
module b4_wr_demux
  import b4_pkg::*;
#(
  parameter int DW = 18,
  parameter int NL = 2,
  parameter int AW = 6,
  localparam int WW = BURST * DW,
  localparam int WB = BURST * NL
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_wr,
  input  beat_ptr_t     start,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wd0,
  input  logic [DW-1:0] wd1,
  input  logic [NL-1:0] wbe0,
  input  logic [NL-1:0] wbe1,
  output logic          collecting,
  output logic          pend_vld,
  output logic [AW-1:0] pend_idx,
  output logic [WW-1:0] pend_data,
  output logic [WB-1:0] pend_be,
  output logic          arr_we,
  output logic [AW-1:0] arr_idx,
  output logic [WW-1:0] arr_data,
  output logic [WB-1:0] arr_be
);
  logic          col_q, col_d;
  logic          pv_q, pv_d;
  beat_ptr_t     h_s;
  logic [AW-1:0] h_idx;
  logic [DW-1:0] h_d0, h_d1;
  logic [NL-1:0] h_be0, h_be1;
  logic [AW-1:0] p_idx;
  logic [WW-1:0] p_data;
  logic [WB-1:0] p_be;
  logic [WW-1:0] asm_d;
  logic [WB-1:0] asm_be;
  logic [DW-1:0] bd [BURST];
  logic [NL-1:0] bb [BURST];

  assign bd[0] = h_d0;
  assign bd[1] = h_d1;
  assign bd[2] = wd0;
  assign bd[3] = wd1;
  assign bb[0] = h_be0;
  assign bb[1] = h_be1;
  assign bb[2] = wbe0;
  assign bb[3] = wbe1;

  // arrival beat k lands in slice start+k, wrapping
  always_comb begin
    beat_ptr_t sl;
    asm_d  = '0;
    asm_be = '0;
    for (int k = 0; k < BURST; k++) begin
      sl = h_s + beat_ptr_t'(k);
      asm_d[int'(sl)*DW +: DW]  = bd[k];
      asm_be[int'(sl)*NL +: NL] = bb[k];
    end
  end

  always_comb begin
    col_d = acc_wr;
    pv_d  = pv_q | col_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= 1'b0;
      pv_q  <= 1'b0;
    end else begin
      col_q <= col_d;
      pv_q  <= pv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (acc_wr) begin
      h_s   <= start;
      h_idx <= idx;
      h_d0  <= wd0;
      h_d1  <= wd1;
      h_be0 <= wbe0;
      h_be1 <= wbe1;
    end
    if (col_q) begin
      p_idx  <= h_idx;
      p_data <= asm_d;
      p_be   <= asm_be;
    end
  end

  // the older pending word is committed when a newer burst completes
  assign arr_we     = col_q & pv_q;
  assign arr_idx    = p_idx;
  assign arr_data   = p_data;
  assign arr_be     = p_be;
  assign collecting = col_q;
  assign pend_vld   = pv_q;
  assign pend_idx   = p_idx;
  assign pend_data  = p_data;
  assign pend_be    = p_be;
endmodule

// File: rtl/b4_word_array.sv
`timescale 1ns/1ps
module b4_word_array #(
  parameter int AW = 6,
  parameter int WB = 8,
  parameter int LW = 9,
  localparam int WW    = WB * LW,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [WW-1:0] wdata,
  input  logic [WB-1:0] wbe,
  input  logic [AW-1:0] ridx,
  output logic [WW-1:0] rdata
);
  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < WB; b++) begin
        if (wbe[b]) mem[widx][b*LW +: LW] <= wdata[b*LW +: LW];
      end
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/b4_rd_mux.sv
`timescale 1ns/1ps
module b4_rd_mux
  import b4_pkg::*;
#(
  parameter int DW = 18,
  parameter int NL = 2,
  parameter int AW = 6,
  localparam int WW = BURST * DW,
  localparam int WB = BURST * NL,
  localparam int LW = DW / NL
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_rd,
  input  beat_ptr_t     start,
  input  logic [AW-1:0] ridx,
  input  logic [WW-1:0] arr_rdata,
  input  logic          pend_vld,
  input  logic [AW-1:0] pend_idx,
  input  logic [WW-1:0] pend_data,
  input  logic [WB-1:0] pend_be,
  output logic [DW-1:0] rd_d0,
  output logic [DW-1:0] rd_d1,
  output logic          rd_vld
);
  logic          hit;
  logic [WW-1:0] mrg;
  logic [WW-1:0] wq;
  beat_ptr_t     sq;
  logic          st1_q, st1_d, st2_q, st2_d, rv_q, rv_d;
  logic [DW-1:0] d0_q, d0_d, d1_q, d1_d;
  beat_ptr_t     p0, p1, p2, p3;

  assign hit = pend_vld && (pend_idx == ridx);

  generate
    for (genvar b = 0; b < WB; b++) begin : g_lane
      assign mrg[b*LW +: LW] = (hit && pend_be[b]) ? pend_data[b*LW +: LW]
                                                   : arr_rdata[b*LW +: LW];
    end
  endgenerate

  always_comb begin
    p0    = sq;
    p1    = sq + 2'd1;
    p2    = sq + 2'd2;
    p3    = sq + 2'd3;
    st1_d = acc_rd;
    st2_d = st1_q;
    rv_d  = st1_q | st2_q;
    if (st1_q) begin
      d0_d = wq[int'(p0)*DW +: DW];
      d1_d = wq[int'(p1)*DW +: DW];
    end else if (st2_q) begin
      d0_d = wq[int'(p2)*DW +: DW];
      d1_d = wq[int'(p3)*DW +: DW];
    end else begin
      d0_d = '0;
      d1_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= 1'b0;
      st2_q <= 1'b0;
      rv_q  <= 1'b0;
      d0_q  <= '0;
      d1_q  <= '0;
    end else begin
      st1_q <= st1_d;
      st2_q <= st2_d;
      rv_q  <= rv_d;
      d0_q  <= d0_d;
      d1_q  <= d1_d;
    end
  end

  always_ff @(posedge clk) begin
    if (acc_rd) begin
      wq <= mrg;
      sq <= start;
    end
  end

  assign rd_d0  = d0_q;
  assign rd_d1  = d1_q;
  assign rd_vld = rv_q;
endmodule

// File: rtl/burst4_sram_dp.sv
`timescale 1ns/1ps
module burst4_sram_dp
  import b4_pkg::*;
#(
  parameter int DW = 18,
  parameter int AW = 6,
  localparam int NL   = lanes_for(DW),
  localparam int LW   = DW / NL,
  localparam int WW   = BURST * DW,
  localparam int WB   = BURST * NL,
  localparam bit WIDE = is_wide(DW),
  localparam int PAW  = WIDE ? AW + 2 : AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_vld,
  input  logic           cmd_wr,
  input  logic [PAW-1:0] cmd_addr,
  input  logic [DW-1:0]  wr_d0,
  input  logic [DW-1:0]  wr_d1,
  input  logic [NL-1:0]  wr_be0,
  input  logic [NL-1:0]  wr_be1,
  output logic [DW-1:0]  rd_d0,
  output logic [DW-1:0]  rd_d1,
  output logic           rd_vld,
  output logic           cmd_err
);
  logic          acc_wr, acc_rd;
  beat_ptr_t     start;
  logic [AW-1:0] idx;
  logic          collecting;
  logic          pend_vld;
  logic [AW-1:0] pend_idx;
  logic [WW-1:0] pend_data;
  logic [WB-1:0] pend_be;
  logic          arr_we;
  logic [AW-1:0] arr_idx;
  logic [WW-1:0] arr_wdata, arr_rdata;
  logic [WB-1:0] arr_be;

  b4_cmd_gate #(.AW(AW), .PAW(PAW), .WIDE(WIDE)) u_gate (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_wr(cmd_wr),
    .cmd_addr(cmd_addr), .acc_wr(acc_wr), .acc_rd(acc_rd),
    .start(start), .idx(idx), .cmd_err(cmd_err)
  );

  b4_wr_demux #(.DW(DW), .NL(NL), .AW(AW)) u_demux (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .start(start), .idx(idx),
    .wd0(wr_d0), .wd1(wr_d1), .wbe0(wr_be0), .wbe1(wr_be1),
    .collecting(collecting), .pend_vld(pend_vld), .pend_idx(pend_idx),
    .pend_data(pend_data), .pend_be(pend_be), .arr_we(arr_we),
    .arr_idx(arr_idx), .arr_data(arr_wdata), .arr_be(arr_be)
  );

  b4_word_array #(.AW(AW), .WB(WB), .LW(LW)) u_array (
    .clk(clk), .we(arr_we), .widx(arr_idx), .wdata(arr_wdata),
    .wbe(arr_be), .ridx(idx), .rdata(arr_rdata)
  );

  b4_rd_mux #(.DW(DW), .NL(NL), .AW(AW)) u_rdmux (
    .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .start(start), .ridx(idx),
    .arr_rdata(arr_rdata), .pend_vld(pend_vld), .pend_idx(pend_idx),
    .pend_data(pend_data), .pend_be(pend_be),
    .rd_d0(rd_d0), .rd_d1(rd_d1), .rd_vld(rd_vld)
  );

  // R3: an accepted read shows valid data two cycles later
  a_r3_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |-> ##2 rd_vld);

  // R10: valid never lasts a single cycle
  a_r10_valid_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_vld) |=> rd_vld);

  // R9: lanes quiet outside a read burst
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_vld |-> (rd_d0 == '0 && rd_d1 == '0));

  // R8: nothing accepted while a write collects its second beat pair
  a_r8_no_accept_mid: assert property (@(posedge clk) disable iff (!rst_n)
    collecting |-> !(acc_wr || acc_rd));

  // R8: the error flag follows a real command strobe
  a_r8_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(cmd_vld));
endmodule

// File: tb/sim_burst4_sram_dp.sv
`timescale 1ns/1ps
module sim_burst4_sram_dp;
  localparam int DW = 18;
  localparam int AW = 6;
  localparam int NL = 2;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          cmd_vld, cmd_wr;
  logic [7:0]    cmd_addr;
  logic [DW-1:0] wd0, wd1, rd0, rd1;
  logic [NL-1:0] be0, be1;
  logic          rvalid, cerr;

  logic       n_vld, n_wr;
  logic [2:0] n_addr;
  logic [8:0] n_wd0, n_wd1, n_rd0, n_rd1;
  logic [0:0] n_be0, n_be1;
  logic       n_rv, n_err;

  burst4_sram_dp #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_wr(cmd_wr),
    .cmd_addr(cmd_addr), .wr_d0(wd0), .wr_d1(wd1), .wr_be0(be0),
    .wr_be1(be1), .rd_d0(rd0), .rd_d1(rd1), .rd_vld(rvalid), .cmd_err(cerr)
  );

  burst4_sram_dp #(.DW(9), .AW(3)) u1 (
    .clk(clk), .rst_n(rst_n), .cmd_vld(n_vld), .cmd_wr(n_wr),
    .cmd_addr(n_addr), .wr_d0(n_wd0), .wr_d1(n_wd1), .wr_be0(n_be0),
    .wr_be1(n_be1), .rd_d0(n_rd0), .rd_d1(n_rd1), .rd_vld(n_rv), .cmd_err(n_err)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_on = 1'b0;

  logic [DW-1:0] refm [DEPTH][4];
  bit            ev [int];
  logic [DW-1:0] e0 [int];
  logic [DW-1:0] e1 [int];
  string         etag [int];
  bit            eerr [int];

  task automatic chk(input string tag, input logic [63:0] act,
                     input logic [63:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the behavioural expectation
  always @(negedge clk) begin
    if (mon_on) begin
      int v;
      v = ev.exists(cyc);
      if (v != 0) begin
        chk(etag[cyc], 64'(rvalid), 64'd1, "rd_vld");
        chk(etag[cyc], 64'(rd0), 64'(e0[cyc]), "lane0 beat");
        chk(etag[cyc], 64'(rd1), 64'(e1[cyc]), "lane1 beat");
      end else begin
        chk("R3", 64'(rvalid), 64'd0, "rd_vld idle");
        chk("R9", 64'({rd1, rd0}), 64'd0, "idle lanes");
      end
      chk("R8", 64'(cerr), 64'(eerr.exists(cyc)), "cmd_err");
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle0();
    cmd_vld = 1'b0; cmd_wr = 1'b0; cmd_addr = '0;
    wd0 = '0; wd1 = '0; be0 = '0; be1 = '0;
  endtask

  task automatic idle1();
    n_vld = 1'b0; n_wr = 1'b0; n_addr = '0;
    n_wd0 = '0; n_wd1 = '0; n_be0 = '0; n_be1 = '0;
  endtask

  // beat k of d at d[k*18 +: 18], enable field l of beat k at be[k*2+l]
  task automatic wr(input int idx, input int s, input logic [71:0] d,
                    input logic [7:0] be, input bit stray);
    for (int k = 0; k < 4; k++) begin
      for (int l = 0; l < 2; l++) begin
        if (be[k*2+l]) refm[idx][(s+k)%4][l*9 +: 9] = d[k*18 + l*9 +: 9];
      end
    end
    cmd_vld = 1'b1; cmd_wr = 1'b1; cmd_addr = 8'(idx*4 + s);
    wd0 = d[17:0]; wd1 = d[35:18]; be0 = be[1:0]; be1 = be[3:2];
    tick();
    if (stray) begin
      cmd_vld = 1'b1; cmd_wr = 1'b0; cmd_addr = 8'((idx ^ 5)*4);
      eerr[cyc+1] = 1'b1;
    end else begin
      cmd_vld = 1'b0;
    end
    wd0 = d[53:36]; wd1 = d[71:54]; be0 = be[5:4]; be1 = be[7:6];
    tick();
    idle0();
  endtask

  task automatic rd(input int idx, input int s, input string tag, input bit stray);
    cmd_vld = 1'b1; cmd_wr = 1'b0; cmd_addr = 8'(idx*4 + s);
    ev[cyc+2] = 1'b1; ev[cyc+3] = 1'b1;
    e0[cyc+2] = refm[idx][s%4];     e1[cyc+2] = refm[idx][(s+1)%4];
    e0[cyc+3] = refm[idx][(s+2)%4]; e1[cyc+3] = refm[idx][(s+3)%4];
    etag[cyc+2] = tag; etag[cyc+3] = tag;
    tick();
    if (stray) begin
      // ignored write to another word, must leave storage untouched
      cmd_vld = 1'b1; cmd_wr = 1'b1; cmd_addr = 8'(((idx + 1) % DEPTH)*4);
      wd0 = 18'h3ffff; wd1 = 18'h3ffff; be0 = 2'b11; be1 = 2'b11;
      eerr[cyc+1] = 1'b1;
    end else begin
      idle0();
    end
    tick();
    idle0();
  endtask

  function automatic logic [71:0] rnd72();
    logic [95:0] r;
    r = {$urandom(), $urandom(), $urandom()};
    return r[71:0];
  endfunction

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle0();
    idle1();
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", 64'(rvalid), 64'd0, "rd_vld after reset");
    chk("R1", 64'(cerr), 64'd0, "cmd_err after reset");
    chk("R1", 64'({rd1, rd0}), 64'd0, "lanes after reset");
    chk("R1", 64'({n_rv, n_err, n_rd1, n_rd0}), 64'd0, "narrow outputs after reset");
    mon_on = 1'b1;
    tick();

    // R2 R4: full-word fill at rotating start offsets
    for (int i = 0; i < DEPTH; i++) wr(i, i % 4, rnd72(), 8'hff, 1'b0);

    // R2 R3 R4 R10: every word at every start, reads back to back
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < DEPTH; i++) rd(i, s, (s == 0) ? "R2,R3,R10" : "R4,R10", 1'b0);
    end

    // R7 R6: partial write then immediate read of the same word (bypass)
    for (int t = 0; t < 40; t++) begin
      int i;
      i = int'($urandom_range(63, 0));
      wr(i, int'($urandom_range(3, 0)), rnd72(), 8'($urandom()), 1'b0);
      rd(i, int'($urandom_range(3, 0)), "R7,R6", 1'b0);
    end

    // R6 R7: partial write, another write commits it, then read from the array
    for (int t = 0; t < 20; t++) begin
      int i;
      i = int'($urandom_range(31, 0));
      wr(i, int'($urandom_range(3, 0)), rnd72(), 8'($urandom()), 1'b0);
      wr(i + 32, int'($urandom_range(3, 0)), rnd72(), 8'hff, 1'b0);
      rd(i, int'($urandom_range(3, 0)), "R6", 1'b0);
    end

    // R6: all enables low leaves the word unchanged
    wr(9, 2, rnd72(), 8'h00, 1'b0);
    rd(9, 1, "R6", 1'b0);

    // R8: stray commands in the second cycle of a burst
    rd(12, 3, "R8", 1'b1);
    rd(13, 0, "R8", 1'b0);
    wr(20, 1, rnd72(), 8'hff, 1'b1);
    rd(20, 1, "R8", 1'b0);
    rd((20 ^ 5), 0, "R8", 1'b0);
    tick();
    tick();

    // R5: narrow variant, no start offset in the address
    n_vld = 1'b1; n_wr = 1'b1; n_addr = 3'd5;
    n_wd0 = 9'h101; n_wd1 = 9'h102; n_be0 = 1'b1; n_be1 = 1'b1;
    tick();
    n_vld = 1'b0; n_wd0 = 9'h103; n_wd1 = 9'h104;
    tick();
    idle1();
    n_vld = 1'b1; n_wr = 1'b0; n_addr = 3'd5;
    tick();
    idle1();
    tick();
    @(negedge clk);
    chk("R5", 64'({n_rv, n_rd1, n_rd0}), 64'({1'b1, 9'h102, 9'h101}), "narrow beats 0,1");
    tick();
    @(negedge clk);
    chk("R5", 64'({n_rv, n_rd1, n_rd0}), 64'({1'b1, 9'h104, 9'h103}), "narrow beats 2,3");
    tick();
    @(negedge clk);
    chk("R9", 64'({n_rv, n_rd1, n_rd0}), 64'd0, "narrow idle");

    // R6 R7 R5: narrow partial write read straight back, then after commit
    n_vld = 1'b1; n_wr = 1'b1; n_addr = 3'd5;
    n_wd0 = 9'h1f1; n_wd1 = 9'h1f2; n_be0 = 1'b1; n_be1 = 1'b0;
    tick();
    n_vld = 1'b0; n_wd0 = 9'h1f3; n_wd1 = 9'h1f4; n_be0 = 1'b1; n_be1 = 1'b0;
    tick();
    idle1();
    n_vld = 1'b1; n_wr = 1'b0; n_addr = 3'd5;
    tick();
    idle1();
    tick();
    @(negedge clk);
    chk("R7", 64'({n_rd1, n_rd0}), 64'({9'h102, 9'h1f1}), "narrow bypass beats 0,1");
    tick();
    @(negedge clk);
    chk("R7", 64'({n_rd1, n_rd0}), 64'({9'h104, 9'h1f3}), "narrow bypass beats 2,3");
    n_vld = 1'b1; n_wr = 1'b1; n_addr = 3'd6;
    n_wd0 = 9'h011; n_wd1 = 9'h012; n_be0 = 1'b1; n_be1 = 1'b1;
    tick();
    n_vld = 1'b0;
    tick();
    idle1();
    n_vld = 1'b1; n_wr = 1'b0; n_addr = 3'd5;
    tick();
    idle1();
    tick();
    @(negedge clk);
    chk("R6", 64'({n_rd1, n_rd0}), 64'({9'h102, 9'h1f1}), "narrow committed beats 0,1");
    tick();
    @(negedge clk);
    chk("R6", 64'({n_rd1, n_rd0}), 64'({9'h104, 9'h1f3}), "narrow committed beats 2,3");
    tick();
    tick();

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule